// File: doc/BRIEF.md
# Prescaler Timer with Watchdog

This block is a free-running binary counter that advances once per main clock. It serves three purposes. First, it is a prescaler: a mode register picks one counter tap and drives it out as a periodic waveform, with either 50% or 75% high time. Second, it gives software a 4-bit view of the upper counter bits, returned inverted. Third, it is a watchdog: if software fails to clear the counter in time, the block raises a one-cycle reset request.

Software controls the block through three strobes. One clears the counter, one captures a readback value and one loads the 4-bit mode register. The mode register is write-only. Bit 3 is a readback-width select and bits 2..0 are a tap code. A separate level input arms the watchdog.

Top module: `prescale_wdt`

## Requirements
- R1: The 17-bit counter increments by one on every clock edge. When `tmr_clr_i` is high at an edge, the counter becomes zero instead. A synchronous active-low reset also zeroes it.
- R2: The readback value is the bitwise inverse of the counter bits it samples. A read taken in the cycle after reset or after a clear returns 4'b1111 when mode bit 3 is 1, and 4'b1000 when mode bit 3 is 0.
- R3: With mode bit 3 = 1, a read strobe captures {~cnt[14], ~cnt[13], ~cnt[12], ~cnt[11]} into `rd_data_o`, with cnt[14] in bit 3. Counter bit n has a period of 2^(n+1) clocks, so these bits are the taps of period 2^15 down to 2^12. The value is taken from the counter before that edge's update.
- R4: With mode bit 3 = 0, a read captures ~cnt[14] into bit 3 and forces bits 2..0 to 0.
- R5: With mode bit 3 = 0, mode bits 2..0 select a waveform on `tick_o` with period 2^k clocks, where k = 10 + ((code+1) >> 1). Code 0 gives a period of 2^10 and code 7 gives 2^14. Measured as phase = count mod 2^k, a 50% wave is high for phase >= 2^(k-1).
- R6: Codes 2, 4 and 6 give 75% duty. The output is high for phase >= 2^(k-2); this equals the OR of counter bits k-1 and k-2. All other codes give 50% duty.
- R7: While mode bit 3 = 1, `tick_o` is held low and the tap code has no effect.
- R8: With `wdg_en_i` high, `wdg_rst_o` goes high for exactly one clock. This is the first cycle in which counter bit 16 is set, which is 65536 clocks after a clear.
- R9: While `wdg_en_i` is low, `wdg_rst_o` stays low even when bit 16 becomes set.
- R10: `rd_data_o` changes only at an edge where `rd_stb_i` is high. Reset sets it to 0.
- R11: The mode register resets to 0 and loads `mode_wdata_i` at an edge where `mode_we_i` is high. A read at that same edge still uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_clr_i | input | 1 | Counter clear strobe |
| rd_stb_i | input | 1 | Readback capture strobe |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 4 | Mode data: bit 3 readback width, bits 2..0 tap code |
| wdg_en_i | input | 1 | Watchdog arm level |
| rd_data_o | output | 4 | Captured inverted counter taps |
| tick_o | output | 1 | Selected periodic waveform |
| wdg_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
A corrupted counter low bit, or a wrong increment, shows on `tick_o` within one period of the selected tap, which is at most 2^14 clocks. The bench compares this output on every cycle against a phase model, so the error is reported at once. An error in bits 11 to 14 shows up in readback only once those bits would have toggled, which takes up to about 2^15 clocks. A fault in the bit-16 edge detection cannot be seen before 65536 clocks after a clear. For that reason one complete watchdog interval is run with the watchdog disarmed and a second with it armed.

// File: rtl/prescale_wdt_pkg.sv
// Package: shared mode type and tap-code decoding for the prescaler timer.
// Assumes the tap codes are a 3-bit field and the period exponent grows by one every two codes.
package prescale_wdt_pkg;

    typedef struct packed {
        logic       wide_rd;   // 1: four readback bits, 0: top bit only
        logic [2:0] tap_code;  // waveform selector, honoured when wide_rd is 0
    } pw_mode_t;

    // Tap offset, above the base tap, of the period bit for a code.
    function automatic int tap_off(input logic [2:0] code);
        return (int'(code) + 1) >> 1;
    endfunction

    // Codes 2, 4 and 6 produce a three-quarter duty waveform.
    function automatic bit tap_wide(input logic [2:0] code);
        return (code != 3'd0) && !code[0];
    endfunction

endpackage

// File: rtl/prescale_wdt_counter.sv
// Module: free-running binary counter with synchronous clear.
// Assumes clear has priority over increment and the counter wraps at 2^CNT_W.
module prescale_wdt_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Next value: zero on clear, otherwise one more.
    always_comb begin
        cnt_nxt = clr_i ? '0 : cnt_q + ONE;
    end

    // Counter state register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // R1: advance by one when not cleared
    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> cnt_q == $past(cnt_q) + ONE);
    // R1: clear zeroes the count
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);

endmodule

// File: rtl/prescale_wdt_tap_sel.sv
// Module: chooses one counter tap, optionally widened to 75% duty, as the periodic output.
// Assumes win_i holds counter bits from the base tap upward, five bits wide.
module prescale_wdt_tap_sel
    import prescale_wdt_pkg::*;
#(
    parameter int WIN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_i,
    input  pw_mode_t         mode_i,
    output logic             tick_o
);

    localparam int NCODE = 8;

    logic [NCODE-1:0] wave;

    // One candidate waveform per tap code.
    for (genvar c = 0; c < NCODE; c++) begin : g_code
        localparam int OFF = tap_off(3'(c));
        if (tap_wide(3'(c))) begin : g_wide
            assign wave[c] = win_i[OFF] | win_i[OFF-1];
        end else begin : g_half
            assign wave[c] = win_i[OFF];
        end
    end

    // Output mux, silenced while the wide readback mode is active.
    always_comb begin
        tick_o = !mode_i.wide_rd && wave[mode_i.tap_code];
    end

    // R7: no waveform while the four-bit readback mode is set
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i.wide_rd |-> !tick_o);
    // R6: a widened waveform is high whenever its period bit is high
    a_r6_cover_half: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i.wide_rd && mode_i.tap_code == 3'd2 && win_i[1]) |-> tick_o);

endmodule

// File: rtl/prescale_wdt_readback.sv
// Module: captures inverted high-order counter bits on a read strobe.
// Assumes tap_i holds the RD_W highest readable bits, MSB first.
module prescale_wdt_readback #(
    parameter int RD_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_i,
    input  logic            wide_i,
    input  logic [RD_W-1:0] tap_i,
    output logic [RD_W-1:0] rd_data_o
);

    logic [RD_W-1:0] view;

    // Inverted taps; only the top bit in narrow mode.
    always_comb begin
        if (wide_i) view = ~tap_i;
        else        view = {~tap_i[RD_W-1], {(RD_W-1){1'b0}}};
    end

    // Capture register updated only by the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    rd_data_o <= '0;
        else if (rd_i) rd_data_o <= view;
    end

    // R10: value holds without a strobe
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o));
    // R4: narrow reads clear the low bits
    a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wide_i) |=> rd_data_o[RD_W-2:0] == '0);

endmodule

// File: rtl/prescale_wdt_watchdog.sv
// Module: flags the first cycle the counter's top bit is set, when armed.
// Assumes the counter is cleared by software often enough in normal use.
module prescale_wdt_watchdog (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic top_q_i,
    input  logic top_nxt_i,
    output logic wdg_rst_o
);

    // Rising edge of the top bit, registered, gated by the arm level.
    always_ff @(posedge clk) begin
        if (!rst_n) wdg_rst_o <= 1'b0;
        else        wdg_rst_o <= en_i && top_nxt_i && !top_q_i;
    end

    // R8: request lasts a single clock
    a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_o |=> !wdg_rst_o);
    // R8: request only while the top bit is set
    a_r8_top_set: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_o |-> top_q_i);
    // R9: disarmed watchdog stays silent
    a_r9_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !wdg_rst_o);

endmodule

// File: rtl/prescale_wdt.sv
// Module: prescaler timer top; counter, mode register, tap output, readback and watchdog.
// Assumes strobes are single-cycle and synchronous to clk; reset is synchronous active-low.
module prescale_wdt
    import prescale_wdt_pkg::*;
#(
    parameter int CNT_W    = 17,
    parameter int TAP_BASE = 9,
    parameter int RD_TOP   = 14,
    parameter int RD_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tmr_clr_i,
    input  logic            rd_stb_i,
    input  logic            mode_we_i,
    input  logic [3:0]      mode_wdata_i,
    input  logic            wdg_en_i,
    output logic [RD_W-1:0] rd_data_o,
    output logic            tick_o,
    output logic            wdg_rst_o
);

    localparam int WIN_W   = 5;
    localparam int WIN_HI  = TAP_BASE + WIN_W - 1;
    localparam int RD_LO   = RD_TOP - RD_W + 1;
    localparam int WDG_BIT = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    pw_mode_t         mode_q;

    // Write-only mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= '0;
        else if (mode_we_i) mode_q <= pw_mode_t'(mode_wdata_i);
    end

    prescale_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr_i),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    prescale_wdt_tap_sel #(.WIN_W(WIN_W)) u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .win_i  (cnt_q[WIN_HI:TAP_BASE]),
        .mode_i (mode_q),
        .tick_o (tick_o)
    );

    prescale_wdt_readback #(.RD_W(RD_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (rd_stb_i),
        .wide_i    (mode_q.wide_rd),
        .tap_i     (cnt_q[RD_TOP:RD_LO]),
        .rd_data_o (rd_data_o)
    );

    prescale_wdt_watchdog u_wdg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (wdg_en_i),
        .top_q_i   (cnt_q[WDG_BIT]),
        .top_nxt_i (cnt_nxt[WDG_BIT]),
        .wdg_rst_o (wdg_rst_o)
    );

    // R11: mode write takes effect at the next edge
    a_r11_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we_i |=> mode_q == pw_mode_t'($past(mode_wdata_i)));

endmodule

// File: tb/tb_prescale_wdt.sv
// Scoreboard bench: a model process queues expected reads, a monitor pops and compares.
module tb_prescale_wdt;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_clr_i = 1'b0;
    logic       rd_stb_i = 1'b0;
    logic       mode_we_i = 1'b0;
    logic [3:0] mode_wdata_i = 4'h0;
    logic       wdg_en_i = 1'b0;
    logic [3:0] rd_data_o;
    logic       tick_o;
    logic       wdg_rst_o;

    int nvec = 0;
    int nfail = 0;
    int pulses = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    logic [16:0] m_cnt = '0;
    logic [3:0]  m_mode = '0;
    logic        m_en = 1'b0;
    bit          rd_pend = 1'b0;
    logic [3:0]  last_rd = '0;
    logic [3:0]  rd_q[$];

    prescale_wdt dut (
        .clk(clk), .rst_n(rst_n), .tmr_clr_i(tmr_clr_i), .rd_stb_i(rd_stb_i),
        .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i), .wdg_en_i(wdg_en_i),
        .rd_data_o(rd_data_o), .tick_o(tick_o), .wdg_rst_o(wdg_rst_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h (count %0d)", req, act, exp, m_cnt);
        end
    endtask

    // Expected readback from the spec: inverted bits 14..11, or top bit only.
    function automatic logic [3:0] exp_read(input logic [16:0] c, input logic [3:0] md);
        if (md[3]) return ~c[14:11];
        return {~c[14], 3'b000};
    endfunction

    // Expected waveform from period and duty of the code.
    function automatic logic exp_tick(input logic [16:0] c, input logic [3:0] md);
        int k;
        int ph;
        int per;
        if (md[3]) return 1'b0;
        k   = 10 + ((int'(md[2:0]) + 1) >> 1);
        per = 1 << k;
        ph  = int'(c) % per;
        if (md[2:0] != 3'd0 && !md[0]) return ph >= per / 4;
        return ph >= per / 2;
    endfunction

    // Driver-side model: queues expected reads and tracks count, mode, arm level.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_mode = '0; rd_pend = 1'b0; m_en = 1'b0;
        end else begin
            if (rd_stb_i) begin
                rd_q.push_back(exp_read(m_cnt, m_mode));
                rd_pend = 1'b1;
            end else begin
                rd_pend = 1'b0;
            end
            m_cnt = tmr_clr_i ? 17'd0 : m_cnt + 17'd1;
            if (mode_we_i) m_mode = mode_wdata_i;
            m_en = wdg_en_i;
        end
    end

    // Monitor: compares outputs every cycle, away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R5/R6/R7 tick", tick_o, exp_tick(m_cnt, m_mode));
            chk("R8/R9 wdg", wdg_rst_o, m_en && m_cnt == 17'h10000);
            if (wdg_rst_o) pulses++;
            if (rd_pend) begin
                last_rd = rd_q.pop_front();
                chk("R2/R3/R4 read", rd_data_o, last_rd);
            end else begin
                chk("R10 hold", rd_data_o, last_rd);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb_i = 1'b1; step(1); rd_stb_i = 1'b0;
    endtask

    task automatic set_mode(input logic [3:0] v);
        mode_wdata_i = v; mode_we_i = 1'b1; step(1); mode_we_i = 1'b0;
    endtask

    task automatic do_clear();
        tmr_clr_i = 1'b1; step(1); tmr_clr_i = 1'b0;
    endtask

    initial begin
        step(5);
        // Reset state: R10 read value, R11 mode 0 gives low tick, R8 no request
        chk("R10 reset rd", rd_data_o, 4'h0);
        chk("R11 reset tick", tick_o, 1'b0);
        chk("R8 reset wdg", wdg_rst_o, 1'b0);
        rst_n = 1'b1;
        step(1);
        mon_on = 1'b1;
        // R2: narrow read right after reset, then R1 clear followed by wide read
        do_read();
        set_mode(4'b1000);
        do_clear();
        do_read();
        chk("R2 all ones after clear", rd_data_o, 4'hF);
        // R11: read on the same edge as a mode write uses the old mode
        mode_wdata_i = 4'b0000; mode_we_i = 1'b1; rd_stb_i = 1'b1;
        step(1);
        mode_we_i = 1'b0; rd_stb_i = 1'b0;
        // R9: watchdog disarmed for a full interval; sweep R5/R6 codes meanwhile
        wdg_en_i = 1'b0;
        do_clear();
        for (int c = 0; c < 8; c++) begin
            int k;
            k = 10 + ((c + 1) >> 1);
            set_mode({1'b0, 3'(c)});
            for (int i = 0; i < (1 << k) / 700; i++) begin
                step(699);
                do_read();
            end
        end
        // R3/R7: wide readback with tap code ignored
        set_mode(4'b1010);
        for (int i = 0; i < 8; i++) begin
            step(1100);
            do_read();
        end
        set_mode(4'b0011);
        while (m_cnt < 17'd65600) step(1);
        chk("R9 no request while disarmed", pulses, 0);
        // R8: armed interval yields exactly one pulse at count 65536
        wdg_en_i = 1'b1;
        do_clear();
        while (m_cnt < 17'd65600) step(1);
        chk("R8 single request", pulses, 1);
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 195000 && !done; t++) @(posedge clk);
        if (!done) begin
            nvec++; nfail++;
            $display("FAIL watchdog timeout actual=running expected=done");
        end
        @(negedge clk);
        mon_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule